// File: doc/BRIEF.md
# Port-Based Pin Multiplexing Register Bank

This block holds the pin-multiplexing and GPIO configuration of a set of I/O ports, each port controlling 32 pins. Software reaches it through a plain 32-bit register read/write bus with byte addresses. Every port owns an identical register set, and the port sets repeat at a 0x100-byte stride. Global pin number g belongs to port g/32 and is port pin g mod 32. Each pin's control outputs are bit or field slices of the stored words. The pad cells and the GPIO data path sit outside the block and consume these outputs.

There are two kinds of control. The first kind is the 1-bit controls: direction, GPIO-in-use, alternate function select and pull-up enable. Each of these is one word per port, with pin n at bit n. The second kind is the 2-bit controls: output select, input select A and input select B. Each of these takes a pair of words. Pins 0 to 15 are in the lower word of the pair and pins 16 to 31 are in the word 4 bytes above it, and each pin takes bits (n mod 16)*2 and the bit above.

Top module: `pinmux_bank`

## Requirements
- R1: After reset every stored word is zero, so every per-pin output is zero and every read returns zero.
- R2: Address bits [7:0] select the register within a port, and the bits above them select the port. Port p's pin n drives output index p*32+n, or the 2-bit field at bits 2*(p*32+n)+1 down to 2*(p*32+n).
- R3: The 1-bit controls sit at these offsets within a port: direction at 0x00, GPIO-in-use at 0x20, alternate function select at 0x38 and pull-up enable at 0x40. Bit n drives pin n on pinDir, pinGpio, pinAltFn and pinPullUp, starting on the clock edge that accepts the write.
- R4: The 2-bit controls use register pairs. Output select is at 0x04 and 0x08, input select A at 0x0C and 0x10, and input select B at 0x14 and 0x18. Pin n < 16 comes from bits 2n+1:2n of the lower word, and pin n >= 16 comes from bits 2(n-16)+1:2(n-16) of the upper word.
- R5: A read of a mapped register returns the whole stored word on rdata in the cycle after rdEn. rdata holds its value while rdEn is low.
- R6: A read of an unmapped offset returns zero. A write to an unmapped offset changes no stored word and no output.
- R7: An access to a port index of NUM_PORTS or higher is ignored on write and reads back as zero.
- R8: When a read and a write to the same register are presented in the same cycle, the read returns the value held before that write. A later read returns the new value.
- R9: A write changes only the addressed register. Without a write, all per-pin outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write request this cycle |
| rdEn | input | 1 | Read request this cycle |
| addr | input | ADDR_W | Byte address: port index above bit 7, register offset in bits 7:0 |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| pinDir | output | NUM_PORTS*32 | Per-pin data direction |
| pinAltFn | output | NUM_PORTS*32 | Per-pin alternate function select |
| pinGpio | output | NUM_PORTS*32 | Per-pin GPIO-in-use |
| pinPullUp | output | NUM_PORTS*32 | Per-pin pull-up enable |
| pinOutSel | output | NUM_PORTS*64 | Per-pin 2-bit output select |
| pinInSelA | output | NUM_PORTS*64 | Per-pin 2-bit input select A |
| pinInSelB | output | NUM_PORTS*64 | Per-pin 2-bit input select B |

## Verification
A read and a write can land on the same register in the same cycle. The register word is updated on the same edge that captures the read data, so these two actions collide. The bench provokes this with a directed case and also with random operations that assert rdEn and wrEn together, sometimes to the same address and sometimes to different addresses. Each read result is compared against a bench model's value taken before the write is applied. Each per-pin output vector is then compared against the model after the write.

// File: rtl/pinmux_pkg.sv
package pinmux_pkg;

  localparam int NKIND = 10;
  localparam int PINS_PER_PORT = 32;

  // register kinds held per port
  localparam int K_DIR  = 0;
  localparam int K_OLO  = 1;
  localparam int K_OHI  = 2;
  localparam int K_ALO  = 3;
  localparam int K_AHI  = 4;
  localparam int K_BLO  = 5;
  localparam int K_BHI  = 6;
  localparam int K_GIUS = 7;
  localparam int K_GPR  = 8;
  localparam int K_PUEN = 9;

  typedef struct packed {
    logic             wr;
    logic             rd;
    logic             hit;
    logic [NKIND-1:0] kind;
  } strobe_t;

  // word index (byte offset / 4) to one-hot register kind
  function automatic logic [NKIND-1:0] decodeWord(input logic [5:0] word);
    logic [NKIND-1:0] k;
    k = '0;
    case (word)
      6'd0:  k[K_DIR]  = 1'b1;
      6'd1:  k[K_OLO]  = 1'b1;
      6'd2:  k[K_OHI]  = 1'b1;
      6'd3:  k[K_ALO]  = 1'b1;
      6'd4:  k[K_AHI]  = 1'b1;
      6'd5:  k[K_BLO]  = 1'b1;
      6'd6:  k[K_BHI]  = 1'b1;
      6'd8:  k[K_GIUS] = 1'b1;
      6'd14: k[K_GPR]  = 1'b1;
      6'd16: k[K_PUEN] = 1'b1;
      default: k = '0;
    endcase
    return k;
  endfunction

endpackage

// File: rtl/pinmux_ctrl.sv
module pinmux_ctrl
  import pinmux_pkg::*;
#(
  parameter int NUM_PORTS = 5,
  parameter int PORT_W    = 3,
  localparam int ADDR_W   = PORT_W + 8
) (
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  output strobe_t           stb,
  output logic [PORT_W-1:0] portIdx
);

  logic portOk;

  always_comb begin
    portIdx  = addr[ADDR_W-1:8];
    portOk   = (32'(portIdx) < 32'(NUM_PORTS));
    stb.kind = portOk ? decodeWord(addr[7:2]) : '0;
    stb.hit  = |stb.kind;
    stb.wr   = wrEn & stb.hit;
    stb.rd   = rdEn;
  end

endmodule

// File: rtl/pinmux_dp.sv
module pinmux_dp
  import pinmux_pkg::*;
#(
  parameter int NUM_PORTS = 5,
  parameter int PORT_W    = 3,
  localparam int NPINS    = NUM_PORTS * PINS_PER_PORT
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            stb,
  input  logic [PORT_W-1:0]  portIdx,
  input  logic [31:0]        wdata,
  output logic [31:0]        rdata,
  output logic [NPINS-1:0]   pinDir,
  output logic [NPINS-1:0]   pinAltFn,
  output logic [NPINS-1:0]   pinGpio,
  output logic [NPINS-1:0]   pinPullUp,
  output logic [2*NPINS-1:0] pinOutSel,
  output logic [2*NPINS-1:0] pinInSelA,
  output logic [2*NPINS-1:0] pinInSelB
);

  logic [31:0] regs [NUM_PORTS][NKIND];
  logic [31:0] rdWord;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int p = 0; p < NUM_PORTS; p++)
        for (int k = 0; k < NKIND; k++)
          regs[p][k] <= '0;
    end else if (stb.wr) begin
      for (int p = 0; p < NUM_PORTS; p++)
        for (int k = 0; k < NKIND; k++)
          if (portIdx == PORT_W'(p) && stb.kind[k])
            regs[p][k] <= wdata;
    end
  end

  always_comb begin
    rdWord = '0;
    for (int p = 0; p < NUM_PORTS; p++)
      for (int k = 0; k < NKIND; k++)
        if (portIdx == PORT_W'(p) && stb.kind[k])
          rdWord = rdWord | regs[p][k];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       rdata <= '0;
    else if (stb.rd) rdata <= rdWord;
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    for (genvar n = 0; n < PINS_PER_PORT; n++) begin : g_pin
      localparam int G = p * PINS_PER_PORT + n;
      assign pinDir[G]    = regs[p][K_DIR][n];
      assign pinGpio[G]   = regs[p][K_GIUS][n];
      assign pinAltFn[G]  = regs[p][K_GPR][n];
      assign pinPullUp[G] = regs[p][K_PUEN][n];
      if (n < 16) begin : g_lo
        assign pinOutSel[2*G +: 2] = regs[p][K_OLO][2*n +: 2];
        assign pinInSelA[2*G +: 2] = regs[p][K_ALO][2*n +: 2];
        assign pinInSelB[2*G +: 2] = regs[p][K_BLO][2*n +: 2];
      end else begin : g_hi
        assign pinOutSel[2*G +: 2] = regs[p][K_OHI][2*(n-16) +: 2];
        assign pinInSelA[2*G +: 2] = regs[p][K_AHI][2*(n-16) +: 2];
        assign pinInSelB[2*G +: 2] = regs[p][K_BHI][2*(n-16) +: 2];
      end
    end
  end

  // R6: decoder never selects two registers at once
  p_kind_onehot_r6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(stb.kind));

  // R7: no write strobe reaches a port outside the bank
  p_wr_port_valid_r7: assert property (@(posedge clk) disable iff (!rstN)
    stb.wr |-> (32'(portIdx) < 32'(NUM_PORTS)));

  // R3: direction write to port 0 shows on the pins next cycle
  p_dir_update_r3: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wr && stb.kind[K_DIR] && portIdx == '0) |=> (pinDir[31:0] == $past(wdata)));

  // R6: unmapped read gives zero
  p_unmapped_zero_r6: assert property (@(posedge clk) disable iff (!rstN)
    (stb.rd && !stb.hit) |=> (rdata == '0));

  // R5: read data holds while idle
  p_rd_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    !stb.rd |=> $stable(rdata));

  // R9: without a write the pin controls stay put
  p_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !stb.wr |=> ($stable(pinDir) && $stable(pinOutSel) && $stable(pinInSelB)));

endmodule

// File: rtl/pinmux_bank.sv
module pinmux_bank
  import pinmux_pkg::*;
#(
  parameter int NUM_PORTS = 5,
  parameter int PORT_W    = 3,
  localparam int ADDR_W   = PORT_W + 8,
  localparam int NPINS    = NUM_PORTS * PINS_PER_PORT
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic               rdEn,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [31:0]        wdata,
  output logic [31:0]        rdata,
  output logic [NPINS-1:0]   pinDir,
  output logic [NPINS-1:0]   pinAltFn,
  output logic [NPINS-1:0]   pinGpio,
  output logic [NPINS-1:0]   pinPullUp,
  output logic [2*NPINS-1:0] pinOutSel,
  output logic [2*NPINS-1:0] pinInSelA,
  output logic [2*NPINS-1:0] pinInSelB
);

  strobe_t           stb;
  logic [PORT_W-1:0] portIdx;

  pinmux_ctrl #(.NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W)) u_ctrl (
    .wrEn(wrEn), .rdEn(rdEn), .addr(addr), .stb(stb), .portIdx(portIdx)
  );

  pinmux_dp #(.NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .portIdx(portIdx), .wdata(wdata),
    .rdata(rdata), .pinDir(pinDir), .pinAltFn(pinAltFn), .pinGpio(pinGpio),
    .pinPullUp(pinPullUp), .pinOutSel(pinOutSel), .pinInSelA(pinInSelA),
    .pinInSelB(pinInSelB)
  );

endmodule

// File: tb/tb_pinmux_bank.sv
`timescale 1ns/1ps
module tb_pinmux_bank;

  localparam int NP = 5;
  localparam int PW = 3;
  localparam int AW = PW + 8;
  localparam int NPINS = NP * 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0, rdEn = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [NPINS-1:0] pinDir, pinAltFn, pinGpio, pinPullUp;
  logic [2*NPINS-1:0] pinOutSel, pinInSelA, pinInSelB;

  int checks = 0, errors = 0;
  logic [31:0] model [NP][10];

  always #4 clk = ~clk;

  pinmux_bank #(.NUM_PORTS(NP), .PORT_W(PW)) dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr), .wdata(wdata),
    .rdata(rdata), .pinDir(pinDir), .pinAltFn(pinAltFn), .pinGpio(pinGpio),
    .pinPullUp(pinPullUp), .pinOutSel(pinOutSel), .pinInSelA(pinInSelA),
    .pinInSelB(pinInSelB)
  );

  // byte offset to model slot, -1 when unmapped
  function automatic int slotOf(input int off);
    case (off)
      'h00: return 0;  'h04: return 1;  'h08: return 2;
      'h0C: return 3;  'h10: return 4;  'h14: return 5;
      'h18: return 6;  'h20: return 7;  'h38: return 8;
      'h40: return 9;  default: return -1;
    endcase
  endfunction

  function automatic logic [31:0] modelRead(input int port, input int off);
    int s;
    s = slotOf(off);
    if (port >= NP || s < 0) return '0;
    return model[port][s];
  endfunction

  function automatic logic [NPINS-1:0] exp1(input int s);
    logic [NPINS-1:0] v;
    for (int p = 0; p < NP; p++)
      for (int n = 0; n < 32; n++) v[p*32+n] = model[p][s][n];
    return v;
  endfunction

  function automatic logic [2*NPINS-1:0] exp2(input int sLo);
    logic [2*NPINS-1:0] v;
    for (int p = 0; p < NP; p++)
      for (int n = 0; n < 32; n++)
        if (n < 16) v[2*(p*32+n) +: 2] = model[p][sLo][2*n +: 2];
        else        v[2*(p*32+n) +: 2] = model[p][sLo+1][2*(n-16) +: 2];
    return v;
  endfunction

  task automatic chk(input string tag, input logic [2*NPINS-1:0] act, input logic [2*NPINS-1:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic checkPins(input string tag);
    chk({tag, " R3 dir"},    {{NPINS{1'b0}}, pinDir},    {{NPINS{1'b0}}, exp1(0)});
    chk({tag, " R3 gpio"},   {{NPINS{1'b0}}, pinGpio},   {{NPINS{1'b0}}, exp1(7)});
    chk({tag, " R3 altfn"},  {{NPINS{1'b0}}, pinAltFn},  {{NPINS{1'b0}}, exp1(8)});
    chk({tag, " R3 pullup"}, {{NPINS{1'b0}}, pinPullUp}, {{NPINS{1'b0}}, exp1(9)});
    chk({tag, " R4 outsel"}, pinOutSel, exp2(1));
    chk({tag, " R4 inselA"}, pinInSelA, exp2(3));
    chk({tag, " R4 inselB"}, pinInSelB, exp2(5));
  endtask

  // one bus cycle; read result expected from state before the write
  task automatic busOp(input bit doW, input bit doR, input int port, input int off,
                       input logic [31:0] d, input string tag);
    logic [31:0] expRd;
    int s;
    @(negedge clk);
    wrEn = doW; rdEn = doR;
    addr = AW'((port << 8) | off);
    wdata = d;
    expRd = modelRead(port, off);
    @(negedge clk);
    wrEn = 1'b0; rdEn = 1'b0;
    if (doR) chk({tag, " R5 read"}, {{(2*NPINS-32){1'b0}}, rdata}, {{(2*NPINS-32){1'b0}}, expRd});
    s = slotOf(off);
    if (doW && port < NP && s >= 0) model[port][s] = d;
    checkPins({tag, " R9"});
  endtask

  task automatic rdCheck(input int port, input int off, input logic [31:0] expv, input string tag);
    @(negedge clk);
    rdEn = 1'b1; addr = AW'((port << 8) | off);
    @(negedge clk);
    rdEn = 1'b0;
    chk(tag, {{(2*NPINS-32){1'b0}}, rdata}, {{(2*NPINS-32){1'b0}}, expv});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int offs [13] = '{'h00,'h04,'h08,'h0C,'h10,'h14,'h18,'h20,'h38,'h40,'h1C,'h24,'hFC};
    void'($urandom(32'd20240611));
    for (int p = 0; p < NP; p++) for (int k = 0; k < 10; k++) model[p][k] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    @(negedge clk);
    checkPins("R1 reset");
    rdCheck(0, 'h38, 32'h0, "R1 reset read");
    rdCheck(4, 'h18, 32'h0, "R1 reset read");

    // R2 R3: port 1 pin 5 direction -> global pin 37
    busOp(1, 0, 1, 'h00, 32'h0000_0020, "R2 dir port1");
    checks++;
    if (pinDir[37] !== 1'b1) begin errors++; $display("FAIL R2 pinDir[37] actual=%b expected=1", pinDir[37]); end

    // R4: pin 16 of port 2 from upper word bits 1:0, pin 15 from lower word bits 31:30
    busOp(1, 0, 2, 'h10, 32'h0000_0003, "R4 inA hi");
    busOp(1, 0, 2, 'h0C, 32'h8000_0000, "R4 inA lo");
    checks++;
    if (pinInSelA[2*80 +: 2] !== 2'b11 || pinInSelA[2*79 +: 2] !== 2'b10) begin
      errors++;
      $display("FAIL R4 insel pins actual=%b/%b expected=11/10", pinInSelA[2*80 +: 2], pinInSelA[2*79 +: 2]);
    end

    // R6: unmapped offset write ignored, reads zero
    busOp(1, 0, 0, 'h1C, 32'hFFFF_FFFF, "R6 unmapped wr");
    rdCheck(0, 'h1C, 32'h0, "R6 unmapped read");

    // R7: port beyond bank ignored, reads zero
    busOp(1, 0, 6, 'h00, 32'hFFFF_FFFF, "R7 bad port wr");
    rdCheck(6, 'h00, 32'h0, "R7 bad port read");
    rdCheck(1, 'h00, 32'h0000_0020, "R7 neighbour intact");

    // R8: read and write to same register in one cycle
    busOp(1, 1, 3, 'h40, 32'hA5A5_0F0F, "R8 same cycle");
    rdCheck(3, 'h40, 32'hA5A5_0F0F, "R8 new value");

    // random mix
    for (int i = 0; i < 600; i++) begin
      int port, off;
      bit w, r;
      port = int'($urandom_range(0, 7));
      off  = offs[$urandom_range(0, 12)];
      w = 1'($urandom_range(0, 1));
      r = 1'($urandom_range(0, 1));
      busOp(w, r, port, off, $urandom, "rand");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule